// File: doc/BRIEF.md
# PLL Reference Switch Sequencer

This block moves a jitter-cleaning PLL between two reference clocks: a local auxiliary clock and a clock recovered from the receive data. A synchronization-messaging block sends it single-cycle commands that ask for one of the two sources. The sequencer answers by running a fixed series of register transfers over an APB3 master port toward the PLL's reconfiguration interface. First it freezes the loop. It then captures the loop's present integer and fractional settings and loads them back as presets. Next it power-cycles the receiver and releases the loop onto the new reference. Last it polls until frequency and phase lock are both reported.

The sequencer and the reconfiguration interface share one clock, so the bus port needs no synchronizers. After reset the PLL is taken to be locked to the auxiliary clock. The block reports `busy` while a switch runs. It ends a switch with either a one-cycle `done` pulse or a held `err` level. `src_rec` always shows which source the block last reached with a good lock.

Top module: `refsw_seq`

## Requirements
- R1: Out of reset, `busy`, `done`, `err`, `src_rec`, `psel` and `penable` are all 0, and `src_rec` = 0 stands for the auxiliary source.
- R2: Each bus transfer has one cycle with `psel`=1, `penable`=0, then one or more cycles with both at 1. `paddr`, `pwrite` and `pwdata` hold steady until a cycle with `pready`=1.
- R3: A command with `cmd_to_rec`=1 while the auxiliary source is current issues, in this order: write CFG_A (0x20) = hold | select(current); read CFG_B (0x24); read CFG_C (0x28); write CFG_B = integer value; write CFG_A = hold | preset-enable | fractional value | select(current); write receiver power-down (0x30) = 1; write it = 0; write CFG_A = preset-enable | fractional value | select(target); then one or more reads of CFG_C.
- R4: Field layout: in CFG_A, hold is bit 0, preset-enable is bit 1, source select is bit 2 (1 = recovered) and the fractional preset is bits 31:8. In CFG_B, the integer preset is written to bits 7:0 and the integer phase-detector value is read from bits 23:16. In CFG_C, frequency lock is bit 0, phase lock is bit 1 and the fractional phase-detector value is read from bits 31:8. In the power-down register, bit 0 = 1 powers the receiver down.
- R5: A command with `cmd_to_rec`=0 while the recovered source is current runs the same sequence, with select(current)=1 and select(target)=0.
- R6: Polling of CFG_C repeats until a read shows both lock bits set. The block then pulses `done` for exactly one cycle, drops `busy` in that same cycle and sets `src_rec` to the target.
- R7: If max(`lock_limit`,1) consecutive polls all lack a lock bit, the sequence ends with `err`=1, no `done` pulse, no further transfer and `src_rec` unchanged.
- R8: A transfer that completes with `pslverr`=1 ends the sequence at once: no further transfer, `err`=1, no `done`, `src_rec` unchanged.
- R9: `err` stays at 1 until the next command is accepted. It reads 0 in the cycle after acceptance.
- R10: A command that arrives while `busy`=1 is ignored. `busy` stays 1 and the transfer series continues unchanged.
- R11: A command that asks for the source already current gives a `done` pulse in the next cycle, issues no bus transfer and leaves `busy` at 0.
- R12: `busy` is 1 from the cycle after a switching command is accepted until the cycle that shows `done` or `err`. No transfer happens while `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the reconfiguration interface |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_to_rec | input | 1 | Requested source: 1 recovered, 0 auxiliary |
| lock_limit | input | CNT_W (16) | Maximum number of lock polls (0 behaves as 1) |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse on a good finish |
| err | output | 1 | Bus error or lock timeout, held until next command |
| src_rec | output | 1 | Current source: 1 recovered, 0 auxiliary |
| paddr | output | ADDR_W (8) | APB3 address |
| psel | output | 1 | APB3 select |
| penable | output | 1 | APB3 enable |
| pwrite | output | 1 | APB3 write |
| pwdata | output | DATA_W (32) | APB3 write data |
| prdata | input | DATA_W (32) | APB3 read data |
| pready | input | 1 | APB3 ready |
| pslverr | input | 1 | APB3 slave error |

## Verification
The bench aims at the points where a sequencer is most likely to be off by one or to leak traffic. One case is the poll counter at its limit, including a limit of 0. A design off by one would make one poll too many or too few before flagging the timeout. A second case is a slave error in the middle of the sequence, where a faulty design would keep writing and could release hold, or would still report `done`. A third is a command that arrives while a switch is running; mishandling it would restart or redirect the sequence. A fourth is a command for the current source, which a wrong design would turn into a full switch. Wait states on `pready` check that a design which does not hold the access phase fails the scoreboard. Changed presets between runs check that a stale capture of the phase-detector fields shows up as a wrong write value.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HOLD_ON,
        S_RD_INT,
        S_RD_FRAC,
        S_WR_INT,
        S_WR_PRESET,
        S_RX_DOWN,
        S_RX_UP,
        S_HOLD_OFF,
        S_POLL
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } apb_ph_e;

    function automatic step_e next_step(step_e s);
        case (s)
            S_HOLD_ON:   return S_RD_INT;
            S_RD_INT:    return S_RD_FRAC;
            S_RD_FRAC:   return S_WR_INT;
            S_WR_INT:    return S_WR_PRESET;
            S_WR_PRESET: return S_RX_DOWN;
            S_RX_DOWN:   return S_RX_UP;
            S_RX_UP:     return S_HOLD_OFF;
            S_HOLD_OFF:  return S_POLL;
            default:     return S_POLL;
        endcase
    endfunction

endpackage

// File: rtl/refsw_apb_master.sv
module refsw_apb_master
    import refsw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              ack_err,
    output logic [DATA_W-1:0] ack_rdata,
    output logic [ADDR_W-1:0] paddr,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);
    apb_ph_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            ack       <= 1'b0;
            ack_err   <= 1'b0;
            ack_rdata <= '0;
            paddr     <= '0;
            pwrite    <= 1'b0;
            pwdata    <= '0;
        end else begin
            ack <= 1'b0;
            case (ph)
                PH_IDLE: if (req_start) begin
                    paddr  <= req_addr;
                    pwrite <= req_wr;
                    pwdata <= req_wdata;
                    ph     <= PH_SETUP;
                end
                PH_SETUP: ph <= PH_ACCESS;
                PH_ACCESS: if (pready) begin
                    ph        <= PH_IDLE;
                    ack       <= 1'b1;
                    ack_err   <= pslverr;
                    ack_rdata <= prdata;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign psel    = (ph != PH_IDLE);
    assign penable = (ph == PH_ACCESS);
endmodule

// File: rtl/refsw_poll_cnt.sv
module refsw_poll_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // the poll now completing is the final one allowed (limit 0 acts as 1)
    assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter logic [ADDR_W-1:0] A_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] B_ADDR  = 8'h24,
    parameter logic [ADDR_W-1:0] C_ADDR  = 8'h28,
    parameter logic [ADDR_W-1:0] PD_ADDR = 8'h30,
    parameter int HOLD_BIT    = 0,
    parameter int PRE_BIT     = 1,
    parameter int SEL_BIT     = 2,
    parameter int FLOCK_BIT   = 0,
    parameter int PLOCK_BIT   = 1,
    parameter int PD_BIT      = 0,
    parameter int INT_W       = 8,
    parameter int INT_PRE_LSB = 0,
    parameter int INT_PD_LSB  = 16,
    parameter int FRAC_W      = 24,
    parameter int FRAC_LSB    = 8,
    parameter int FRAC_PD_LSB = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_to_rec,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              src_rec,
    output logic              req_start,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              ack,
    input  logic              ack_err,
    input  logic [DATA_W-1:0] rdata,
    output logic              poll_clr,
    output logic              poll_inc,
    input  logic              poll_last
);
    localparam logic [DATA_W-1:0] HOLD_M = DATA_W'(1) << HOLD_BIT;
    localparam logic [DATA_W-1:0] PRE_M  = DATA_W'(1) << PRE_BIT;
    localparam logic [DATA_W-1:0] SEL_M  = DATA_W'(1) << SEL_BIT;
    localparam logic [DATA_W-1:0] PD_M   = DATA_W'(1) << PD_BIT;

    step_e             step;
    logic              pend;
    logic              tgt_q;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              locked;
    logic              unused_rd;
    logic [DATA_W-1:0] frac_word;

    assign locked    = rdata[FLOCK_BIT] && rdata[PLOCK_BIT];
    assign unused_rd = ^rdata;
    assign frac_word = DATA_W'(frac_q) << FRAC_LSB;

    assign busy      = (step != S_IDLE);
    assign req_start = busy && !pend;
    assign poll_clr  = (step == S_IDLE) && cmd_valid;
    assign poll_inc  = (step == S_POLL) && pend && ack && !ack_err
                       && !locked && !poll_last;

    always_comb begin
        req_wr    = 1'b0;
        req_addr  = C_ADDR;
        req_wdata = '0;
        case (step)
            S_HOLD_ON:   begin req_wr = 1'b1; req_addr = A_ADDR;
                               req_wdata = HOLD_M | (src_rec ? SEL_M : '0); end
            S_RD_INT:    req_addr = B_ADDR;
            S_WR_INT:    begin req_wr = 1'b1; req_addr = B_ADDR;
                               req_wdata = DATA_W'(int_q) << INT_PRE_LSB; end
            S_WR_PRESET: begin req_wr = 1'b1; req_addr = A_ADDR;
                               req_wdata = HOLD_M | PRE_M | frac_word
                                           | (src_rec ? SEL_M : '0); end
            S_RX_DOWN:   begin req_wr = 1'b1; req_addr = PD_ADDR; req_wdata = PD_M; end
            S_RX_UP:     begin req_wr = 1'b1; req_addr = PD_ADDR; end
            S_HOLD_OFF:  begin req_wr = 1'b1; req_addr = A_ADDR;
                               req_wdata = PRE_M | frac_word | (tgt_q ? SEL_M : '0); end
            default:     req_addr = C_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= S_IDLE;
            pend    <= 1'b0;
            tgt_q   <= 1'b0;
            src_rec <= 1'b0;
            int_q   <= '0;
            frac_q  <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (step == S_IDLE) begin
                if (cmd_valid) begin
                    err  <= 1'b0;
                    pend <= 1'b0;
                    if (cmd_to_rec == src_rec) begin
                        done <= 1'b1;
                    end else begin
                        tgt_q <= cmd_to_rec;
                        step  <= S_HOLD_ON;
                    end
                end
            end else if (!pend) begin
                pend <= 1'b1;
            end else if (ack) begin
                pend <= 1'b0;
                if (ack_err) begin
                    step <= S_IDLE;
                    err  <= 1'b1;
                end else if (step == S_POLL) begin
                    if (locked) begin
                        step    <= S_IDLE;
                        done    <= 1'b1;
                        src_rec <= tgt_q;
                    end else if (poll_last) begin
                        step <= S_IDLE;
                        err  <= 1'b1;
                    end
                end else begin
                    if (step == S_RD_INT)  int_q  <= rdata[INT_PD_LSB +: INT_W];
                    if (step == S_RD_FRAC) frac_q <= rdata[FRAC_PD_LSB +: FRAC_W];
                    step <= next_step(step);
                end
            end
        end
    end
endmodule

// File: rtl/refsw_seq.sv
module refsw_seq
    import refsw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter logic [ADDR_W-1:0] A_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] B_ADDR  = 8'h24,
    parameter logic [ADDR_W-1:0] C_ADDR  = 8'h28,
    parameter logic [ADDR_W-1:0] PD_ADDR = 8'h30,
    parameter int HOLD_BIT    = 0,
    parameter int PRE_BIT     = 1,
    parameter int SEL_BIT     = 2,
    parameter int FLOCK_BIT   = 0,
    parameter int PLOCK_BIT   = 1,
    parameter int PD_BIT      = 0,
    parameter int INT_W       = 8,
    parameter int INT_PRE_LSB = 0,
    parameter int INT_PD_LSB  = 16,
    parameter int FRAC_W      = 24,
    parameter int FRAC_LSB    = 8,
    parameter int FRAC_PD_LSB = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_to_rec,
    input  logic [CNT_W-1:0]  lock_limit,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              src_rec,
    output logic [ADDR_W-1:0] paddr,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);
    logic              req_start, req_wr, ack, ack_err;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, ack_rdata;
    logic              poll_clr, poll_inc, poll_last;

    refsw_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .A_ADDR(A_ADDR), .B_ADDR(B_ADDR), .C_ADDR(C_ADDR), .PD_ADDR(PD_ADDR),
        .HOLD_BIT(HOLD_BIT), .PRE_BIT(PRE_BIT), .SEL_BIT(SEL_BIT),
        .FLOCK_BIT(FLOCK_BIT), .PLOCK_BIT(PLOCK_BIT), .PD_BIT(PD_BIT),
        .INT_W(INT_W), .INT_PRE_LSB(INT_PRE_LSB), .INT_PD_LSB(INT_PD_LSB),
        .FRAC_W(FRAC_W), .FRAC_LSB(FRAC_LSB), .FRAC_PD_LSB(FRAC_PD_LSB)
    ) ctrl_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_to_rec(cmd_to_rec),
        .busy(busy), .done(done), .err(err), .src_rec(src_rec),
        .req_start(req_start), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .ack_err(ack_err), .rdata(ack_rdata),
        .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last)
    );

    refsw_apb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) apb_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .ack_err(ack_err),
        .ack_rdata(ack_rdata), .paddr(paddr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr)
    );

    refsw_poll_cnt #(.CNT_W(CNT_W)) poll_i (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc),
        .limit(lock_limit), .last(poll_last)
    );
endmodule

// File: rtl/refsw_seq_chk.sv
module refsw_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              src_rec,
    input logic [ADDR_W-1:0] paddr,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready
);
    assert_setup_then_access_R2: assert property (@(posedge clk) disable iff (rst)
        psel && !penable |=> psel && penable);

    assert_enable_with_select_R2: assert property (@(posedge clk) disable iff (rst)
        penable |-> psel);

    assert_access_held_R2: assert property (@(posedge clk) disable iff (rst)
        psel && penable && !pready |=>
            penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_clean_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !err);

    assert_idle_no_bus_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !psel);

    assert_src_moves_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(src_rec) |-> done);

    assert_err_from_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(busy));
endmodule

bind refsw_seq refsw_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .src_rec(src_rec), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .pready(pready)
);

// File: tb/refsw_seq_tb_top.sv
`timescale 1ns/1ps
module refsw_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_to_rec = 1'b0;
    logic [15:0] lock_limit = 16'd8;
    logic        busy, done, err, src_rec;
    logic [7:0]  paddr;
    logic        psel, penable, pwrite;
    logic [31:0] pwdata;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;

    always #2.5 clk = ~clk;

    refsw_seq dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_to_rec(cmd_to_rec),
        .lock_limit(lock_limit), .busy(busy), .done(done), .err(err),
        .src_rec(src_rec), .paddr(paddr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr)
    );

    typedef struct {
        logic [7:0]  a;
        logic        w;
        logic [31:0] d;
    } item_t;

    item_t       expq[$];
    int          checks = 0;
    int          fails  = 0;
    int          xfers  = 0;
    logic [31:0] mem [0:63];
    int          wait_n = 0;
    int          wcnt = 0;
    int          lock_after = 0;
    int          c_polls = 0;
    bit          hold_off_seen = 0;
    bit          err_arm = 0;
    logic [7:0]  err_addr = 8'h00;
    bit          got_done, got_err;

    task automatic check(bit ok, string req, string what,
                         logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [7:0] a, logic w, logic [31:0] d);
        item_t it;
        it.a = a; it.w = w; it.d = d;
        expq.push_back(it);
    endtask

    // expected traffic for one switch (R3, R4, R5)
    task automatic expect_switch(bit cur, bit tgt, logic [7:0] iv,
                                 logic [23:0] fv, int polls);
        push(8'h20, 1'b1, 32'h1 | (32'(cur) << 2));
        push(8'h24, 1'b0, 32'h0);
        push(8'h28, 1'b0, 32'h0);
        push(8'h24, 1'b1, 32'(iv));
        push(8'h20, 1'b1, 32'h3 | (32'(fv) << 8) | (32'(cur) << 2));
        push(8'h30, 1'b1, 32'h1);
        push(8'h30, 1'b1, 32'h0);
        push(8'h20, 1'b1, 32'h2 | (32'(fv) << 8) | (32'(tgt) << 2));
        for (int i = 0; i < polls; i++) push(8'h28, 1'b0, 32'h0);
    endtask

    task automatic load_pll(logic [7:0] iv, logic [23:0] fv);
        mem[9]  = 32'(iv) << 16;
        mem[10] = 32'(fv) << 8;
        hold_off_seen = 0;
        c_polls = 0;
    endtask

    // monitor: compares each completed transfer against the queue
    task automatic observe(logic [7:0] a, logic w, logic [31:0] d);
        item_t e;
        xfers++;
        if (expq.size() == 0) begin
            check(1'b0, "R10", "unexpected transfer addr", 32'(a), 32'h0);
        end else begin
            e = expq.pop_front();
            check(a == e.a, "R3", "transfer addr", 32'(a), 32'(e.a));
            check(w == e.w, "R3", "transfer direction", 32'(w), 32'(e.w));
            if (e.w) check(d == e.d, "R4", "write data", d, e.d);
        end
    endtask

    // APB3 slave model standing in for the PLL
    always @(negedge clk) begin
        if (psel && penable && !pready) begin
            if (wcnt < wait_n) begin
                wcnt++;
            end else begin
                logic [31:0] rd;
                logic        se;
                se = err_arm && (paddr == err_addr);
                if (se) err_arm = 0;
                rd = mem[paddr[7:2]];
                if (paddr == 8'h28) begin
                    rd[1:0] = (hold_off_seen && c_polls >= lock_after) ? 2'b11 : 2'b00;
                    if (hold_off_seen) c_polls++;
                end
                if (pwrite && !se) begin
                    mem[paddr[7:2]] = pwdata;
                    if (paddr == 8'h20 && !pwdata[0]) hold_off_seen = 1;
                end
                prdata  = rd;
                pslverr = se;
                pready  = 1'b1;
                observe(paddr, pwrite, pwdata);
            end
        end else if (!(psel && penable)) begin
            pready  = 1'b0;
            pslverr = 1'b0;
            wcnt    = 0;
        end
    end

    task automatic send_cmd(bit to_rec);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_to_rec = to_rec;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_end();
        got_done = 0;
        got_err  = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
        got_done = done;
        got_err  = err;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int x0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy after reset", 32'(busy), 0);
        check(done == 0, "R1", "done after reset", 32'(done), 0);
        check(err == 0, "R1", "err after reset", 32'(err), 0);
        check(src_rec == 0, "R1", "src_rec after reset", 32'(src_rec), 0);
        check(psel == 0 && penable == 0, "R1", "bus idle after reset",
              32'({psel, penable}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11: request auxiliary while on auxiliary
        x0 = xfers;
        send_cmd(1'b0);
        check(done == 1, "R11", "done on same source", 32'(done), 1);
        check(busy == 0, "R11", "busy on same source", 32'(busy), 0);
        repeat (3) @(negedge clk);
        check(xfers == x0, "R11", "no traffic on same source", 32'(xfers), 32'(x0));

        // R3 R4 R6: switch to recovered, lock on third poll
        load_pll(8'h5A, 24'h123456);
        lock_after = 2; lock_limit = 16'd8; wait_n = 0;
        expect_switch(1'b0, 1'b1, 8'h5A, 24'h123456, 3);
        send_cmd(1'b1);
        check(busy == 1, "R12", "busy after accept", 32'(busy), 1);
        wait_end();
        check(got_done && !got_err, "R6", "done after lock", 32'({got_done, got_err}), 2);
        check(src_rec == 1, "R6", "src_rec after enable", 32'(src_rec), 1);
        check(busy == 0, "R12", "busy at done", 32'(busy), 0);
        @(negedge clk);
        check(done == 0, "R6", "done lasts one cycle", 32'(done), 0);
        check(expq.size() == 0, "R3", "all enable transfers seen", 32'(expq.size()), 0);

        // R5 R10: switch back with wait states and a command while busy
        load_pll(8'hC3, 24'hABCDEF);
        lock_after = 1; wait_n = 2;
        expect_switch(1'b1, 1'b0, 8'hC3, 24'hABCDEF, 2);
        send_cmd(1'b0);
        repeat (3) @(negedge clk);
        send_cmd(1'b1);
        check(busy == 1, "R10", "busy kept after ignored command", 32'(busy), 1);
        wait_end();
        check(got_done, "R5", "done after disable", 32'(got_done), 1);
        check(src_rec == 0, "R5", "src_rec after disable", 32'(src_rec), 0);
        check(expq.size() == 0, "R10", "sequence unchanged", 32'(expq.size()), 0);

        // R7: lock timeout after three polls
        load_pll(8'h11, 24'h000222);
        lock_after = 100; lock_limit = 16'd3; wait_n = 0;
        expect_switch(1'b0, 1'b1, 8'h11, 24'h000222, 3);
        send_cmd(1'b1);
        wait_end();
        check(got_err && !got_done, "R7", "error on timeout", 32'({got_done, got_err}), 1);
        check(src_rec == 0, "R7", "src_rec kept on timeout", 32'(src_rec), 0);
        x0 = xfers;
        repeat (5) @(negedge clk);
        check(err == 1, "R9", "err held", 32'(err), 1);
        check(xfers == x0, "R7", "no traffic after timeout", 32'(xfers), 32'(x0));
        check(expq.size() == 0, "R7", "poll count at limit", 32'(expq.size()), 0);

        // R7 R9: limit 0 allows one poll; err clears on accept
        load_pll(8'h22, 24'h000333);
        lock_limit = 16'd0;
        expect_switch(1'b0, 1'b1, 8'h22, 24'h000333, 1);
        send_cmd(1'b1);
        check(err == 0, "R9", "err cleared on accept", 32'(err), 0);
        wait_end();
        check(got_err, "R7", "error with limit 0", 32'(got_err), 1);
        check(expq.size() == 0, "R7", "single poll with limit 0", 32'(expq.size()), 0);

        // R8: slave error on the power-down write
        load_pll(8'h44, 24'h000555);
        lock_after = 0; lock_limit = 16'd8;
        err_arm = 1; err_addr = 8'h30;
        push(8'h20, 1'b1, 32'h1);
        push(8'h24, 1'b0, 32'h0);
        push(8'h28, 1'b0, 32'h0);
        push(8'h24, 1'b1, 32'h44);
        push(8'h20, 1'b1, 32'h3 | (32'h555 << 8));
        push(8'h30, 1'b1, 32'h1);
        send_cmd(1'b1);
        wait_end();
        check(got_err && !got_done, "R8", "abort on slave error", 32'({got_done, got_err}), 1);
        x0 = xfers;
        repeat (6) @(negedge clk);
        check(xfers == x0, "R8", "no traffic after abort", 32'(xfers), 32'(x0));
        check(src_rec == 0, "R8", "src_rec kept on abort", 32'(src_rec), 0);

        // R2 R6: long wait states, immediate lock
        load_pll(8'h7E, 24'hFEDCBA);
        lock_after = 0; wait_n = 3;
        expect_switch(1'b0, 1'b1, 8'h7E, 24'hFEDCBA, 1);
        send_cmd(1'b1);
        wait_end();
        check(got_done, "R2", "done with wait states", 32'(got_done), 1);
        check(src_rec == 1, "R6", "src_rec recovered", 32'(src_rec), 1);

        // R11: request recovered while on recovered
        x0 = xfers;
        send_cmd(1'b1);
        check(done == 1, "R11", "done on same source", 32'(done), 1);
        repeat (4) @(negedge clk);
        check(xfers == x0, "R11", "no traffic on same source", 32'(xfers), 32'(x0));

        finish_run();
    end
endmodule